// File: doc/BRIEF.md
# Sequential Word Divider with Condition Flags

This unit divides a double-width dividend by a single-width divisor over many clock cycles, one quotient bit per cycle. It works in unsigned mode or in two's-complement signed mode. The result comes back as one packed word: the quotient sits in the low half and the remainder in the high half. The unit also produces four condition flags and raises a trap request when the divisor is zero.

A CPU datapath pulses `start` with the operands and the mode, then waits for `done`. The unit completes after a fixed number of cycles, which is a parameter and differs between the two modes, so a sequencer can schedule around it. `res_valid` tells the datapath whether to write the packed word back. When it is low, because of an overflow or a zero divisor, the result register keeps its earlier value.

Top module: `wdiv_seq`

## Requirements
- R1: With `mode`=0, the operands are unsigned. `result[QW-1:0]` holds the quotient and `result[DW-1:QW]` holds the remainder of `dividend / divisor`, where DW = 2*QW.
- R2: With `mode`=1, both operands are two's complement. The quotient is truncated toward zero. Its magnitude is negated when exactly one operand is negative, and the remainder carries the sign of the dividend.
- R3: Only `divisor[QW-1:0]` takes part in the division. The upper bits of `divisor` have no effect on any output.
- R4: In unsigned mode, a quotient of 2^QW or more is an overflow. `flag_v` is set to 1, `flag_c` is cleared, `res_valid` stays 0, and `result`, `flag_n` and `flag_z` keep their earlier values.
- R5: In signed mode, a quotient outside -2^(QW-1) .. 2^(QW-1)-1 is an overflow. It is handled exactly as in R4.
- R6: On a valid completion, `flag_n` is bit QW-1 of the quotient, `flag_z` is 1 when the QW-bit quotient is zero, and `flag_v` and `flag_c` are 0.
- R7: A zero in `divisor[QW-1:0]` raises `trap_req` for one cycle together with `done`, and `res_valid` stays 0. `trap_vec` always presents TRAP_VEC (0x14 by default). `result` and all four flags keep their earlier values.
- R8: A `start` that is sampled while the unit is idle produces exactly one one-cycle `done` pulse. The pulse is high after clock edge LAT_U (unsigned) or LAT_S (signed), counting the edge that sampled `start` as edge 0.
- R9: A `start` that arrives while `busy` is high is ignored. It produces no extra `done` pulse and does not change the result of the operation already running.
- R10: After reset, `done`, `trap_req`, `res_valid` and `busy` are 0, and `result` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division when idle |
| mode | input | 1 | 0 = unsigned, 1 = signed |
| dividend | input | DW | Dividend, full width |
| divisor | input | DW | Divisor; only the low QW bits are used |
| result | output | DW | Packed word: remainder in the high half, quotient in the low half |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| trap_req | output | 1 | Divide-by-zero trap request pulse |
| trap_vec | output | 8 | Trap vector offset |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | High with `done` when `result` was written |
| busy | output | 1 | Division in progress |

## Verification
The bench builds the unit with QW=4, so the dividend and the divisor port are each 8 bits wide. It sets LAT_U=10 and LAT_S=12. At this size, every dividend is run against every low divisor nibble in both modes, while the upper divisor bits take a value that changes from one operation to the next. The sweep therefore covers every signed and unsigned overflow boundary, the most-negative operands, and every zero divisor. Each completion is also checked for the exact cycle of its `done` pulse, and a separate case pulses `start` in the middle of an operation.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } wdiv_flags_t;

   localparam logic [7:0] WDIV_ZERO_VEC = 8'h14;
endpackage

// File: rtl/wdiv_cond.sv
// Turns the operands into magnitudes and records which signs the results need.
module wdiv_cond #(
   parameter int QW        = 16,
   parameter bit SIGNED_EN = 1'b1,
   localparam int DW       = 2 * QW
) (
   input  logic          mode,
   input  logic [DW-1:0] dvd,
   input  logic [QW-1:0] dvs,
   output logic [DW-1:0] dvd_mag,
   output logic [QW-1:0] dvs_mag,
   output logic          neg_q,
   output logic          neg_r
);
   generate
      if (SIGNED_EN) begin : g_signed
         logic dvd_neg, dvs_neg;
         always_comb begin
            dvd_neg = mode & dvd[DW-1];
            dvs_neg = mode & dvs[QW-1];
            dvd_mag = dvd_neg ? -dvd : dvd;
            dvs_mag = dvs_neg ? -dvs : dvs;
            neg_q   = dvd_neg ^ dvs_neg;
            neg_r   = dvd_neg;
         end
      end else begin : g_unsigned
         logic unused_mode;
         always_comb begin
            unused_mode = mode;
            dvd_mag     = dvd;
            dvs_mag     = dvs;
            neg_q       = 1'b0;
            neg_r       = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/wdiv_core.sv
// Restoring shift-and-subtract loop: one quotient bit per step.
module wdiv_core #(
   parameter int QW  = 16,
   localparam int DW = 2 * QW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [DW-1:0] dvd_mag,
   input  logic [QW-1:0] dvs_mag,
   output logic [DW-1:0] quo,
   output logic [QW-1:0] rem
);
   logic [DW-1:0] quo_r;
   logic [QW-1:0] rem_r;
   logic [QW-1:0] dvs_r;
   logic [QW:0]   trial;
   logic [QW:0]   diff;
   logic          fits;

   always_comb begin
      trial = {rem_r, quo_r[DW-1]};
      diff  = trial - {1'b0, dvs_r};
      fits  = trial >= {1'b0, dvs_r};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_r <= '0;
         rem_r <= '0;
         dvs_r <= '0;
      end else if (load) begin
         quo_r <= dvd_mag;
         rem_r <= '0;
         dvs_r <= dvs_mag;
      end else if (step) begin
         quo_r <= {quo_r[DW-2:0], fits};
         rem_r <= fits ? diff[QW-1:0] : trial[QW-1:0];
      end
   end

   assign quo = quo_r;
   assign rem = rem_r;
endmodule

// File: rtl/wdiv_post.sv
// Restores the signs, detects overflow and forms the flags.
module wdiv_post
   import wdiv_pkg::*;
#(
   parameter int QW  = 16,
   localparam int DW = 2 * QW
) (
   input  logic          mode,
   input  logic          neg_q,
   input  logic          neg_r,
   input  logic [DW-1:0] quo_mag,
   input  logic [QW-1:0] rem_mag,
   output logic [DW-1:0] packed_res,
   output logic          ovf,
   output wdiv_flags_t   flags
);
   localparam logic [DW-1:0] POS_LIM = DW'(1) << (QW - 1);

   logic [DW-1:0] q_full;
   logic [QW-1:0] q_out;
   logic [QW-1:0] r_out;
   logic          ovf_u, ovf_s;

   always_comb begin
      q_full     = neg_q ? -quo_mag : quo_mag;
      q_out      = q_full[QW-1:0];
      r_out      = neg_r ? -rem_mag : rem_mag;
      ovf_u      = |quo_mag[DW-1:QW];
      ovf_s      = neg_q ? (quo_mag > POS_LIM) : (quo_mag >= POS_LIM);
      ovf        = mode ? ovf_s : ovf_u;
      packed_res = {r_out, q_out};
      flags.n    = q_out[QW-1];
      flags.z    = (q_out == '0);
      flags.v    = 1'b0;
      flags.c    = 1'b0;
   end
endmodule

// File: rtl/wdiv_seq.sv
module wdiv_seq
   import wdiv_pkg::*;
#(
   parameter int         QW        = 16,
   parameter int         LAT_U     = 140,
   parameter int         LAT_S     = 158,
   parameter bit         SIGNED_EN = 1'b1,
   parameter logic [7:0] TRAP_VEC  = WDIV_ZERO_VEC,
   localparam int        DW        = 2 * QW,
   localparam int        LMAX      = (LAT_U > LAT_S) ? LAT_U : LAT_S,
   localparam int        CW        = $clog2(LMAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          mode,
   input  logic [DW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic [DW-1:0] result,
   output logic          flag_n,
   output logic          flag_z,
   output logic          flag_v,
   output logic          flag_c,
   output logic          trap_req,
   output logic [7:0]    trap_vec,
   output logic          done,
   output logic          res_valid,
   output logic          busy
);
   generate
      if (QW < 2 || QW > 31) begin : g_bad_qw
         $error("wdiv_seq: QW must lie in 2..31");
      end
      if (LAT_U < DW + 1 || LAT_S < DW + 1) begin : g_bad_lat
         $error("wdiv_seq: latencies must cover DW loop steps plus one");
      end
   endgenerate

   logic          eff_mode;
   logic          accept;
   logic          step;
   logic          finish;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lat_r;
   logic          mode_r, nq_r, nr_r, dz_r;
   logic [DW-1:0] dvd_mag, quo_mag, packed_res;
   logic [QW-1:0] dvs_mag, rem_mag;
   logic          nq_c, nr_c, ovf;
   wdiv_flags_t   nflags;

   assign eff_mode = SIGNED_EN ? mode : 1'b0;
   assign accept   = start && !busy;
   assign step     = busy && (cnt <= CW'(DW));
   assign finish   = busy && (cnt == lat_r);
   assign trap_vec = TRAP_VEC;

   wdiv_cond #(.QW(QW), .SIGNED_EN(SIGNED_EN)) u_cond (
      .mode   (eff_mode),
      .dvd    (dividend),
      .dvs    (divisor[QW-1:0]),
      .dvd_mag(dvd_mag),
      .dvs_mag(dvs_mag),
      .neg_q  (nq_c),
      .neg_r  (nr_c)
   );

   wdiv_core #(.QW(QW)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .step   (step),
      .dvd_mag(dvd_mag),
      .dvs_mag(dvs_mag),
      .quo    (quo_mag),
      .rem    (rem_mag)
   );

   wdiv_post #(.QW(QW)) u_post (
      .mode      (mode_r),
      .neg_q     (nq_r),
      .neg_r     (nr_r),
      .quo_mag   (quo_mag),
      .rem_mag   (rem_mag),
      .packed_res(packed_res),
      .ovf       (ovf),
      .flags     (nflags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cnt       <= '0;
         lat_r     <= '0;
         mode_r    <= 1'b0;
         nq_r      <= 1'b0;
         nr_r      <= 1'b0;
         dz_r      <= 1'b0;
         done      <= 1'b0;
         trap_req  <= 1'b0;
         res_valid <= 1'b0;
         result    <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_v    <= 1'b0;
         flag_c    <= 1'b0;
      end else begin
         done      <= 1'b0;
         trap_req  <= 1'b0;
         res_valid <= 1'b0;
         if (accept) begin
            busy   <= 1'b1;
            cnt    <= CW'(1);
            lat_r  <= eff_mode ? CW'(LAT_S) : CW'(LAT_U);
            mode_r <= eff_mode;
            nq_r   <= nq_c;
            nr_r   <= nr_c;
            dz_r   <= (divisor[QW-1:0] == '0);
         end else if (busy) begin
            cnt <= cnt + CW'(1);
            if (finish) begin
               busy <= 1'b0;
               done <= 1'b1;
               if (dz_r) begin
                  trap_req <= 1'b1;
               end else if (ovf) begin
                  flag_v <= 1'b1;
                  flag_c <= 1'b0;
               end else begin
                  result    <= packed_res;
                  res_valid <= 1'b1;
                  flag_n    <= nflags.n;
                  flag_z    <= nflags.z;
                  flag_v    <= nflags.v;
                  flag_c    <= nflags.c;
               end
            end
         end
      end
   end
endmodule

// File: rtl/wdiv_seq_chk.sv
module wdiv_seq_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          res_valid,
   input logic          trap_req,
   input logic          flag_v,
   input logic          flag_c,
   input logic [DW-1:0] result
);
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_trap_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (done && !res_valid));

   p_valid_clear_vc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_valid) |-> (!flag_v && !flag_c));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_v) |-> !res_valid);

   p_hold_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !res_valid) |-> $stable(result));
endmodule

bind wdiv_seq wdiv_seq_chk #(.DW(DW)) u_wdiv_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .res_valid(res_valid),
   .trap_req (trap_req),
   .flag_v   (flag_v),
   .flag_c   (flag_c),
   .result   (result)
);

// File: tb/wdiv_seq_test.sv
module wdiv_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int QW  = 4;
   localparam int DW  = 8;
   localparam int LU  = 10;
   localparam int LS  = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode = 1'b0;
   logic [DW-1:0] dividend = '0;
   logic [DW-1:0] divisor = '0;
   logic [DW-1:0] result;
   logic          flag_n, flag_z, flag_v, flag_c;
   logic          trap_req, done, res_valid, busy;
   logic [7:0]    trap_vec;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] m_res = '0;
   logic          m_n = 0, m_z = 0, m_v = 0, m_c = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdiv_seq #(.QW(QW), .LAT_U(LU), .LAT_S(LS)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .dividend(dividend), .divisor(divisor), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
      .trap_req(trap_req), .trap_vec(trap_vec), .done(done),
      .res_valid(res_valid), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Called at a negedge; leaves the bench at the negedge after completion.
   task automatic run_op(input bit md, input logic [DW-1:0] a,
                         input logic [DW-1:0] d, input bit poke);
      int lat, sa, sd, q, r;
      bit dz, ov, early;
      lat = md ? LS : LU;
      dz  = (d[QW-1:0] == 0);
      if (md) begin
         sa = a[DW-1] ? int'(a) - 256 : int'(a);
         sd = d[QW-1] ? int'(d[QW-1:0]) - 16 : int'(d[QW-1:0]);
      end else begin
         sa = int'(a);
         sd = int'(d[QW-1:0]);
      end
      q = 0; r = 0; ov = 0;
      if (!dz) begin
         q  = sa / sd;
         r  = sa % sd;
         ov = md ? (q > 7 || q < -8) : (q > 15);
      end
      mode = md; dividend = a; divisor = d; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      early = 0;
      for (int k = 1; k < lat; k++) begin
         if (poke && k == 3) begin
            start = 1'b1; dividend = ~a; divisor = d ^ 8'h03; mode = ~md;
         end
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         if (done) early = 1;
      end
      @(posedge clk);
      @(negedge clk);
      chk(done && !early, md ? "R8 signed done timing" : "R8 unsigned done timing",
          {31'd0, done}, 32'd1);
      if (dz) begin
         chk(trap_req && !res_valid && trap_vec == 8'h14, "R7 zero divisor trap",
             {trap_req, res_valid, trap_vec}, {1'b1, 1'b0, 8'h14});
      end else if (ov) begin
         m_v = 1; m_c = 0;
         chk(!res_valid && !trap_req, md ? "R5 signed overflow no write" :
             "R4 unsigned overflow no write", {res_valid, trap_req}, 0);
      end else begin
         m_res = {4'(r), 4'(q)};
         m_n = q[3]; m_z = (4'(q) == 4'd0); m_v = 0; m_c = 0;
         chk(res_valid && !trap_req, "R6 valid completion", {res_valid, trap_req}, 2);
      end
      chk(result == m_res, md ? "R2 R3 signed result" : "R1 R3 unsigned result",
          result, m_res);
      chk({flag_n, flag_z, flag_v, flag_c} == {m_n, m_z, m_v, m_c},
          dz ? "R7 flags held" : (ov ? "R4 R5 overflow flags" : "R6 flags"),
          {flag_n, flag_z, flag_v, flag_c}, {m_n, m_z, m_v, m_c});
      if (poke) begin
         @(posedge clk);
         @(negedge clk);
         chk(!done && !busy, "R9 start while busy ignored", {done, busy}, 0);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk({done, trap_req, res_valid, busy} == 0 && result == 0 &&
          {flag_n, flag_z, flag_v, flag_c} == 0, "R10 reset state",
          {done, trap_req, res_valid, busy, flag_n, flag_z, flag_v, flag_c, result},
          0);
      rst_n = 1'b1;
      @(negedge clk);
      // R3: the same division with the upper divisor bits at both extremes
      run_op(1'b0, 8'd100, 8'h07, 1'b0);
      run_op(1'b0, 8'd100, 8'hF7, 1'b0);
      run_op(1'b1, 8'hC3, 8'h05, 1'b0);
      run_op(1'b1, 8'hC3, 8'hA5, 1'b0);
      // R9: start pulsed in the middle of an operation
      run_op(1'b0, 8'd77, 8'h09, 1'b1);
      run_op(1'b1, 8'h9D, 8'h0D, 1'b1);
      // R1 R2 R4 R5 R7: exhaustive sweep in both modes
      for (int md = 0; md < 2; md++) begin
         for (int a = 0; a < 256; a++) begin
            for (int d = 0; d < 16; d++) begin
               run_op(md[0], 8'(a), {4'(a + d * 3) ^ 4'h5, 4'(d)}, 1'b0);
            end
         end
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule